// File: doc/BRIEF.md
# Dual-Clock Gauging Counter

This block measures how long a software-defined window lasts, against two reference rates at the same time. One is a slow 32768 Hz tick and the other is a fast 12 MHz tick. Each reference reaches the block as a one-cycle enable pulse in the system clock domain. Software opens the window by setting bit 0 of the gate register and closes it by clearing that bit. When the window closes, the block copies both tick counts into read-only result registers. It then sets completion and overflow flags and raises an interrupt.

Software reads the 32-bit results as 16-bit low and high halves. It reads the status register to acknowledge the interrupt, and that read also clears the status. A controller with three named states sequences each measurement:

- `GW_IDLE`: no window is open. The transition *start* leads to `GW_RUN`.
- `GW_RUN`: the counters advance on their ticks. The transition *stop* leads to `GW_LATCH`.
- `GW_LATCH`: a one-cycle state in which the counts are copied out and the flags are set. From here the controller returns to `GW_IDLE`, or it takes *start* straight back to `GW_RUN`.

Top module: `gauge_unit`

## Requirements
- R1: After reset, every register reads 0 at offsets 0x00, 0x04, 0x08, 0x0C, 0x10 and 0x14, and `gauge_irq` is low.
- R2: The window opens only when a write to offset 0x10 changes bit 0 from 0 to 1. A write that keeps bit 0 at 1 neither restarts nor clears the counts. Offset 0x10 reads back the last value written to it.
- R3: The slow count is the number of cycles with `slow_tick` high from the cycle after the opening write through the cycle of the closing write. Its bits 15:0 appear at offset 0x00 and its bits 31:16 at offset 0x04.
- R4: The fast count is defined the same way on `fast_tick`. Its bits 15:0 appear at offset 0x08 and its bits 31:16 at offset 0x0C.
- R5: A 1-to-0 write to bit 0 of offset 0x10 closes the window. Two clock edges after that write, the results are updated, status bit 0 is 1 and `gauge_irq` is high. One edge after the write, `gauge_irq` is still low.
- R6: If the slow count exceeds the counter width, status bit 2 is set. The result shows the count modulo 2^width.
- R7: If the fast count exceeds the counter width, status bit 1 is set. The result shows the count modulo 2^width.
- R8: A read of offset 0x14 returns the status (bits 2:0, upper bits 0). The read then clears the status to 0 and drops `gauge_irq`.
- R9: Writes to offsets 0x00, 0x04, 0x08, 0x0C and 0x14 are ignored. Results, status and `gauge_irq` keep their values.
- R10: The result registers keep their last latched values while a new window is running.
- R11: Ticks that arrive while no window is open change neither the results nor the next measurement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slow_tick | input | 1 | One-cycle pulse at the slow reference rate |
| fast_tick | input | 1 | One-cycle pulse at the fast reference rate |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (clears status at offset 0x14) |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from `bus_addr` |
| gauge_irq | output | 1 | Measurement-complete interrupt |

## Verification
A wrong controller state shows up at the ports within two cycles of the closing write. A stuck `GW_RUN` never raises `gauge_irq`. A skipped `GW_LATCH` leaves stale results. A spurious restart gives a count that is short by the ticks before the restart. A counter that misses its clear or its enable shows up the next time results are read, as a count that is off by an exact, predictable number of ticks. Lost overflow state is detected by windows that run past 2^width ticks.

// File: rtl/gauge_pkg.sv
package gauge_pkg;

    typedef enum logic [1:0] {
        GW_IDLE  = 2'd0,
        GW_RUN   = 2'd1,
        GW_LATCH = 2'd2
    } gw_state_t;

    localparam int OFS_SLOW_LO = 8'h00;
    localparam int OFS_SLOW_HI = 8'h04;
    localparam int OFS_FAST_LO = 8'h08;
    localparam int OFS_FAST_HI = 8'h0C;
    localparam int OFS_GATE    = 8'h10;
    localparam int OFS_STATUS  = 8'h14;

    localparam int STAT_DONE  = 0;
    localparam int STAT_FOVF  = 1;
    localparam int STAT_SOVF  = 2;

endpackage

// File: rtl/gauge_tick_counter.sv
module gauge_tick_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         en,
    input  logic         tick,
    output logic [W-1:0] count,
    output logic         ovf
);

    logic [W-1:0] cnt_q;
    logic         ovf_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            ovf_q <= 1'b0;
        end else if (clear) begin
            cnt_q <= '0;
            ovf_q <= 1'b0;
        end else if (en && tick) begin
            cnt_q <= cnt_q + 1'b1;
            if (&cnt_q) begin
                ovf_q <= 1'b1;
            end
        end
    end

    assign count = cnt_q;
    assign ovf   = ovf_q;

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !clear) |=> ovf); // R6

    AST_WRAP_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (en && tick && !clear && (&count)) |=> (ovf && count == '0)); // R7

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !clear) |=> ($stable(count) && $stable(ovf))); // R11

endmodule

// File: rtl/gauge_window_fsm.sv
module gauge_window_fsm
    import gauge_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic stop,
    output logic cnt_clear,
    output logic cnt_en,
    output logic take
);

    gw_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= GW_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GW_IDLE:  if (start) state_d = GW_RUN;
            GW_RUN:   if (stop)  state_d = GW_LATCH;
            GW_LATCH: state_d = start ? GW_RUN : GW_IDLE;
            default:  state_d = GW_IDLE;
        endcase
    end

    always_comb begin
        cnt_clear = 1'b0;
        cnt_en    = 1'b0;
        take      = 1'b0;
        unique case (state_q)
            GW_IDLE:  cnt_clear = start;
            GW_RUN:   cnt_en    = 1'b1;
            GW_LATCH: begin
                take      = 1'b1;
                cnt_clear = start;
            end
            default: ;
        endcase
    end

    AST_LATCH_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == GW_LATCH) |-> $past(stop)); // R5

    AST_LATCH_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == GW_LATCH) |=> (state_q != GW_LATCH)); // R5

    AST_START_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
        (start && state_q != GW_RUN) |=> (state_q == GW_RUN)); // R2

endmodule

// File: rtl/gauge_unit.sv
module gauge_unit
    import gauge_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int SLOW_W = 32,
    parameter int FAST_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slow_tick,
    input  logic              fast_tick,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [15:0]       bus_wdata,
    output logic [15:0]       bus_rdata,
    output logic              gauge_irq
);

    localparam int RES_W  = 32;
    localparam int STAT_W = 3;

    logic [15:0]       gate_q;
    logic [STAT_W-1:0] status_q;
    logic              irq_q;
    logic [SLOW_W-1:0] slow_res_q;
    logic [FAST_W-1:0] fast_res_q;

    logic [SLOW_W-1:0] slow_cnt;
    logic [FAST_W-1:0] fast_cnt;
    logic              slow_ovf, fast_ovf;
    logic              cnt_clear, cnt_en, take;
    logic              gate_wr, start, stop, status_rd;
    logic [RES_W-1:0]  slow_ext, fast_ext;

    assign gate_wr   = bus_wr && (bus_addr == ADDR_W'(OFS_GATE));
    assign start     = gate_wr &&  bus_wdata[0] && !gate_q[0];
    assign stop      = gate_wr && !bus_wdata[0] &&  gate_q[0];
    assign status_rd = bus_rd && (bus_addr == ADDR_W'(OFS_STATUS));

    gauge_window_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .stop      (stop),
        .cnt_clear (cnt_clear),
        .cnt_en    (cnt_en),
        .take      (take)
    );

    gauge_tick_counter #(.W(SLOW_W)) u_slow (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (cnt_clear),
        .en    (cnt_en),
        .tick  (slow_tick),
        .count (slow_cnt),
        .ovf   (slow_ovf)
    );

    gauge_tick_counter #(.W(FAST_W)) u_fast (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (cnt_clear),
        .en    (cnt_en),
        .tick  (fast_tick),
        .count (fast_cnt),
        .ovf   (fast_ovf)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gate_q <= '0;
        end else if (gate_wr) begin
            gate_q <= bus_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slow_res_q <= '0;
            fast_res_q <= '0;
        end else if (take) begin
            slow_res_q <= slow_cnt;
            fast_res_q <= fast_cnt;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= '0;
            irq_q    <= 1'b0;
        end else if (take) begin
            status_q[STAT_DONE] <= 1'b1;
            status_q[STAT_FOVF] <= fast_ovf || (!status_rd && status_q[STAT_FOVF]);
            status_q[STAT_SOVF] <= slow_ovf || (!status_rd && status_q[STAT_SOVF]);
            irq_q               <= 1'b1;
        end else if (status_rd) begin
            status_q <= '0;
            irq_q    <= 1'b0;
        end
    end

    assign slow_ext  = RES_W'(slow_res_q);
    assign fast_ext  = RES_W'(fast_res_q);
    assign gauge_irq = irq_q;

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            ADDR_W'(OFS_SLOW_LO): bus_rdata = slow_ext[15:0];
            ADDR_W'(OFS_SLOW_HI): bus_rdata = slow_ext[31:16];
            ADDR_W'(OFS_FAST_LO): bus_rdata = fast_ext[15:0];
            ADDR_W'(OFS_FAST_HI): bus_rdata = fast_ext[31:16];
            ADDR_W'(OFS_GATE):    bus_rdata = gate_q;
            ADDR_W'(OFS_STATUS):  bus_rdata = 16'(status_q);
            default:              bus_rdata = '0;
        endcase
    end

    AST_IRQ_MEANS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        gauge_irq |-> status_q[STAT_DONE]); // R5

    AST_STATUS_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (status_rd && !take) |=> (status_q == '0 && !gauge_irq)); // R8

    AST_RESULTS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_en |=> ($stable(slow_res_q) && $stable(fast_res_q))); // R10

    AST_RO_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !gate_wr && !bus_rd && !take) |=> $stable(status_q)); // R9

endmodule

// File: tb/sim_gauge_unit.sv
`timescale 1ns/1ps
module sim_gauge_unit;

    localparam int S0 = 17, F0 = 16;
    localparam int S1 = 8,  F1 = 17;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        slow_tick = 1'b0, fast_tick = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] rdata0, rdata1;
    logic        irq0, irq1;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    gauge_unit #(.ADDR_W(8), .SLOW_W(S0), .FAST_W(F0)) u0 (
        .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .fast_tick(fast_tick),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(rdata0), .gauge_irq(irq0));

    gauge_unit #(.ADDR_W(8), .SLOW_W(S1), .FAST_W(F1)) u1 (
        .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .fast_tick(fast_tick),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(rdata1), .gauge_irq(irq1));

    task automatic chk(input string tag, input longint got, input longint exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [15:0] d0, output logic [15:0] d1);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1;
        d0 = rdata0; d1 = rdata1;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    // Expected result registers and status of one instance, from the tick counts.
    task automatic chk_inst(input string tag, input int idx, input longint es, input longint ef,
                            input logic [15:0] d_slo, input logic [15:0] d_shi,
                            input logic [15:0] d_flo, input logic [15:0] d_fhi);
        int sw, fw;
        longint ms, mf;
        sw = (idx == 0) ? S0 : S1;
        fw = (idx == 0) ? F0 : F1;
        ms = es % (longint'(1) << sw);
        mf = ef % (longint'(1) << fw);
        chk({tag, " R3 slow lo"}, d_slo, ms & 16'hFFFF);
        chk({tag, " R3 slow hi"}, d_shi, (ms >> 16) & 16'hFFFF);
        chk({tag, " R4 fast lo"}, d_flo, mf & 16'hFFFF);
        chk({tag, " R4 fast hi"}, d_fhi, (mf >> 16) & 16'hFFFF);
    endtask

    function automatic longint exp_status(input int idx, input longint es, input longint ef);
        int sw, fw;
        sw = (idx == 0) ? S0 : S1;
        fw = (idx == 0) ? F0 : F1;
        return 1 + ((es >= (longint'(1) << fw) ? 0 : 0))
                 + ((ef >= (longint'(1) << fw)) ? 2 : 0)
                 + ((es >= (longint'(1) << sw)) ? 4 : 0);
    endfunction

    task automatic chk_results(input string tag, input longint es, input longint ef);
        logic [15:0] a0, a1, b0, b1, c0, c1, e0, e1;
        rd(8'h00, a0, a1);
        rd(8'h04, b0, b1);
        rd(8'h08, c0, c1);
        rd(8'h0C, e0, e1);
        chk_inst({tag, " u0"}, 0, es, ef, a0, b0, c0, e0);
        chk_inst({tag, " u1"}, 1, es, ef, a1, b1, c1, e1);
    endtask

    task automatic chk_status_and_clear(input string tag, input longint es, input longint ef);
        logic [15:0] s0, s1;
        chk({tag, " R5 irq u0"}, irq0, 1);
        rd(8'h14, s0, s1);
        chk({tag, " R8 status u0"}, s0, exp_status(0, es, ef));
        chk({tag, " R8 status u1"}, s1, exp_status(1, es, ef));
        chk({tag, " R8 irq dropped"}, irq0, 0);
        rd(8'h14, s0, s1);
        chk({tag, " R8 status cleared"}, s0, 0);
    endtask

    // Open a window, drive n tick cycles, close it; counts the ticks driven.
    task automatic window(input int n, input int sp, input int fp, input bit rewrite,
                          output longint es, output longint ef);
        es = 0; ef = 0;
        wr(8'h10, 16'h0001);
        for (int k = 0; k < n; k++) begin
            if (rewrite && k == n / 2) begin
                slow_tick = 1'b0; fast_tick = 1'b0;
                wr(8'h10, 16'h0003);
            end
            slow_tick = (sp != 0) && (k % sp == 0);
            fast_tick = (fp != 0) && (k % fp == 0);
            es += slow_tick; ef += fast_tick;
            @(negedge clk);
        end
        slow_tick = 1'b0; fast_tick = 1'b0;
        wr(8'h10, 16'h0000);
        chk("R5 irq low one edge after close", irq0, 0);
        @(negedge clk);
        chk("R5 irq high two edges after close", irq0, 1);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog R1..R11 actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        longint es, ef, os, of;
        logic [15:0] d0, d1;
        int sweep_n  [4] = '{40, 100, 17, 0};
        int sweep_sp [4] = '{4, 3, 1, 0};
        int sweep_fp [4] = '{1, 7, 0, 2};

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        for (int a = 0; a <= 'h14; a += 4) begin
            rd(8'(a), d0, d1);
            chk($sformatf("R1 reset offset %0h u0", a), d0, 0);
            chk($sformatf("R1 reset offset %0h u1", a), d1, 0);
        end
        chk("R1 irq after reset", irq0, 0);

        // R11: ticks while idle do not leak into a later window
        slow_tick = 1'b1; fast_tick = 1'b1;
        repeat (20) @(negedge clk);
        slow_tick = 1'b0; fast_tick = 1'b0;

        // R3/R4/R5/R8: sweep of window lengths and tick patterns
        for (int i = 0; i < 4; i++) begin
            window(sweep_n[i], sweep_sp[i], sweep_fp[i], 1'b0, es, ef);
            chk_results($sformatf("sweep%0d", i), es, ef);
            chk_status_and_clear($sformatf("sweep%0d", i), es, ef);
        end

        // R2: gate write keeping bit 0 set does not restart; gate readback
        window(60, 2, 1, 1'b1, es, ef);
        chk_results("R2 rewrite", es, ef);
        rd(8'h10, d0, d1);
        chk("R2 gate readback after close", d0, 16'h0000);

        // R9: writes to read-only offsets ignored
        wr(8'h00, 16'hFFFF); wr(8'h04, 16'hFFFF); wr(8'h08, 16'hFFFF);
        wr(8'h0C, 16'hFFFF); wr(8'h14, 16'hFFFF);
        chk_results("R9 ro writes", es, ef);
        chk("R9 irq kept", irq0, 1);
        chk_status_and_clear("R9 ro writes", es, ef);
        os = es; of = ef;

        // R10: results hold during a running window; R11: idle ticks ignored
        wr(8'h10, 16'h0001);
        rd(8'h10, d0, d1);
        chk("R2 gate readback open", d0, 16'h0001);
        slow_tick = 1'b1; fast_tick = 1'b1;
        repeat (10) @(negedge clk);
        slow_tick = 1'b0; fast_tick = 1'b0;
        chk_results("R10 mid-window", os, of);
        slow_tick = 1'b1; fast_tick = 1'b1;
        repeat (5) @(negedge clk);
        slow_tick = 1'b0; fast_tick = 1'b0;
        wr(8'h10, 16'h0000);
        @(negedge clk);
        slow_tick = 1'b1; fast_tick = 1'b1;
        repeat (20) @(negedge clk);
        slow_tick = 1'b0; fast_tick = 1'b0;
        chk_results("R10 R11 after idle ticks", 15, 15);
        chk_status_and_clear("R10 window", 15, 15);

        // R6/R7: long window, both ticks every cycle
        window(65540, 1, 1, 1'b0, es, ef);
        chk_results("R6 R7 overflow", es, ef);
        chk_status_and_clear("R6 R7 overflow", es, ef);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule